// File: doc/BRIEF.md
# Asynchronous FIFO Write Strobe Sequencer

This block turns a stream of bytes on a valid/ready handshake into the pin-level write cycles of an asynchronous slave FIFO. It drives the FIFO address, an active-low chip select, an active-low write strobe, an 8-bit data bus and an active-low packet-end strobe, and it samples the FIFO's full flag. Each pin timing is a whole number of system clock cycles set by a parameter. The slave takes a byte on the rising edge of the write strobe.

A byte whose address differs from the one on the bus first gets an address setup phase. A byte that keeps the current address goes straight into a new strobe. In a burst, consecutive strobes are separated only by the shortest high time the timing rules allow. A short packet is closed with a separate packet-end pulse. The write strobe is high during that pulse, the write strobe has met its minimum high time before the pulse starts, and the address does not change while the pulse lasts. While the full flag reads active, no new byte is accepted and no new strobe starts.

Top module: `fifo_wr_seq`

## Requirements
- R1: During and after reset, until the first byte is accepted, `fifo_cs_n`, `fifo_wr_n` and `fifo_pktend_n` are high, `s_ready` is high and `pkt_ready` is low.
- R2: A byte is accepted on a clock edge where `s_valid` and `s_ready` are both high. If its address differs from the address on `fifo_addr`, or it is the first byte after reset, `fifo_addr` shows the new address for exactly T_SFA cycles before `fifo_wr_n` falls. `fifo_addr` does not change while `fifo_wr_n` is low.
- R3: `fifo_wr_n` stays low for exactly max(T_WRPWL, T_SFD) cycles. `fifo_data` is constant during that time and for at least T_FDH cycles after the rising edge.
- R4: Between two write strobes, `fifo_wr_n` is high for at least T_WRPWH cycles. When a byte with the same address is offered without a gap, the high time is exactly max(T_WRPWH, T_FDH, T_XFLG+1) cycles.
- R5: `fifo_cs_n` goes low no later than `fifo_wr_n` does, and it is low in every cycle in which `fifo_wr_n` is low.
- R6: When `fifo_full` (active high) was high at the previous clock edge, `s_ready` is low. No new write strobe begins while `fifo_full` is held. Acceptance resumes one cycle after `fifo_full` falls.
- R7: `pkt_ready` is high only when the sequencer is idle between writes and `s_valid` is low. A commit is accepted when `pkt_req` and `pkt_ready` are both high. It produces one `fifo_pktend_n` low pulse of exactly T_PEPWL cycles, followed by at least T_PEPWH high cycles before the next strobe.
- R8: `fifo_pktend_n` and `fifo_wr_n` are never low in the same cycle. `fifo_pktend_n` falls only after `fifo_wr_n` has been high for at least T_WRPWH cycles.
- R9: `fifo_addr` is constant for the whole `fifo_pktend_n` low pulse.
- R10: Every accepted byte produces exactly one write strobe. Strobes come in acceptance order, and each carries its own address and data at the rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| s_addr | input | AW | FIFO address for the offered byte |
| s_data | input | DW | Offered byte |
| s_valid | input | 1 | Byte offer valid |
| s_ready | output | 1 | Sequencer can take a byte |
| pkt_req | input | 1 | Request to commit a short packet |
| pkt_ready | output | 1 | Commit request can be taken |
| fifo_addr | output | AW | FIFO address pins |
| fifo_cs_n | output | 1 | Chip select, active low |
| fifo_wr_n | output | 1 | Write strobe, active low |
| fifo_data | output | DW | FIFO data bus |
| fifo_pktend_n | output | 1 | Packet-end strobe, active low |
| fifo_full | input | 1 | FIFO full flag, active high |

## Verification
A new address gives a write-strobe fall exactly T_SFA cycles after the acceptance edge. A same-address byte starts its strobe on the acceptance edge itself. The strobe then rises max(T_WRPWL, T_SFD) cycles later. `s_ready` reflects `fifo_full` one cycle after the flag changes. A packet-end pulse begins on the edge that accepts `pkt_req`.

The bench samples all pins on the falling clock edge. It measures every width as a run of consecutive samples and records the address age at each strobe fall. It then compares these measured cycle counts against the expected counts, which it derives from the timing parameters. It also compares the address and data captured at each strobe rise with the vector that was offered.

// File: rtl/fifo_wr_seq_pkg.sv
package fifo_wr_seq_pkg;

  typedef enum logic [2:0] {
    S_IDLE,   // nothing written since reset, select released
    S_ASET,   // new address on the bus, waiting for its setup time
    S_WLO,    // write strobe low
    S_WHI,    // write strobe high, hold and flag delay running
    S_RDY,    // address held, ready for a byte or a commit
    S_PLO,    // packet-end strobe low
    S_PHI     // packet-end strobe high recovery
  } wseq_state_e;

  function automatic int unsigned wseq_max(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/fifo_wr_seq_timer.sv
module fifo_wr_seq_timer #(
  parameter int unsigned TW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [TW-1:0] val,
  output logic          expire
);

  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (load) begin
      cnt_q <= val;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  // last cycle of a phase loaded with val cycles
  assign expire = (cnt_q == TW'(1));

endmodule

// File: rtl/fifo_wr_seq_flag.sv
module fifo_wr_seq_flag (
  input  logic clk,
  input  logic fifo_full,
  output logic full_q
);

  // one sampling register, free running so it is valid right out of reset
  always_ff @(posedge clk) begin
    full_q <= fifo_full;
  end

endmodule

// File: rtl/fifo_wr_seq_fsm.sv
module fifo_wr_seq_fsm
  import fifo_wr_seq_pkg::*;
#(
  parameter int unsigned AW     = 2,
  parameter int unsigned DW     = 8,
  parameter int unsigned TW     = 4,
  parameter int unsigned N_SFA  = 1,
  parameter int unsigned N_LOW  = 1,
  parameter int unsigned N_GAP  = 1,
  parameter int unsigned N_PLO  = 1,
  parameter int unsigned N_PHI  = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_data,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          pkt_req,
  output logic          pkt_ready,
  input  logic          full_q,
  output logic          tmr_load,
  output logic [TW-1:0] tmr_val,
  input  logic          tmr_exp,
  output logic [AW-1:0] fifo_addr,
  output logic          fifo_cs_n,
  output logic          fifo_wr_n,
  output logic [DW-1:0] fifo_data,
  output logic          fifo_pktend_n
);

  wseq_state_e state_q, state_d;
  logic        accept;
  logic        pkt_go;
  logic        same_addr;

  assign s_ready   = ((state_q == S_IDLE) || (state_q == S_RDY)) && !full_q;
  assign pkt_ready = (state_q == S_RDY) && !s_valid;
  assign accept    = s_valid && s_ready;
  assign pkt_go    = pkt_req && pkt_ready;
  assign same_addr = (s_addr == fifo_addr);

  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    case (state_q)
      S_IDLE: begin
        if (accept) begin
          state_d  = S_ASET;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_SFA);
        end
      end
      S_RDY: begin
        if (accept && same_addr) begin
          state_d  = S_WLO;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_LOW);
        end else if (accept) begin
          state_d  = S_ASET;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_SFA);
        end else if (pkt_go) begin
          state_d  = S_PLO;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_PLO);
        end
      end
      S_ASET: begin
        if (tmr_exp) begin
          state_d  = S_WLO;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_LOW);
        end
      end
      S_WLO: begin
        if (tmr_exp) begin
          state_d  = S_WHI;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_GAP);
        end
      end
      S_WHI: begin
        if (tmr_exp) state_d = S_RDY;
      end
      S_PLO: begin
        if (tmr_exp) begin
          state_d  = S_PHI;
          tmr_load = 1'b1;
          tmr_val  = TW'(N_PHI);
        end
      end
      S_PHI: begin
        if (tmr_exp) state_d = S_RDY;
      end
      default: state_d = S_IDLE;
    endcase
  end

  // pins are registered from the next state so they change with state_q
  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= S_IDLE;
      fifo_addr     <= '0;
      fifo_data     <= '0;
      fifo_cs_n     <= 1'b1;
      fifo_wr_n     <= 1'b1;
      fifo_pktend_n <= 1'b1;
    end else begin
      state_q       <= state_d;
      fifo_cs_n     <= (state_d == S_IDLE);
      fifo_wr_n     <= (state_d != S_WLO);
      fifo_pktend_n <= (state_d != S_PLO);
      if (accept) begin
        fifo_addr <= s_addr;
        fifo_data <= s_data;
      end
    end
  end

endmodule

// File: rtl/fifo_wr_seq.sv
module fifo_wr_seq
  import fifo_wr_seq_pkg::*;
#(
  parameter int unsigned AW      = 2,
  parameter int unsigned DW      = 8,
  parameter int unsigned T_SFA   = 2,
  parameter int unsigned T_WRPWL = 3,
  parameter int unsigned T_WRPWH = 2,
  parameter int unsigned T_SFD   = 2,
  parameter int unsigned T_FDH   = 1,
  parameter int unsigned T_XFLG  = 2,
  parameter int unsigned T_PEPWL = 2,
  parameter int unsigned T_PEPWH = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] s_addr,
  input  logic [DW-1:0] s_data,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic          pkt_req,
  output logic          pkt_ready,
  output logic [AW-1:0] fifo_addr,
  output logic          fifo_cs_n,
  output logic          fifo_wr_n,
  output logic [DW-1:0] fifo_data,
  output logic          fifo_pktend_n,
  input  logic          fifo_full
);

  // strobe low covers both the minimum width and data setup
  localparam int unsigned N_LOW = wseq_max(T_WRPWL, T_SFD);
  // full high time between burst strobes; the ready cycle is its last cycle
  localparam int unsigned N_HIW = wseq_max(wseq_max(T_WRPWH, T_FDH), T_XFLG + 1);
  localparam int unsigned N_GAP = N_HIW - 1;
  localparam int unsigned N_MAX = wseq_max(wseq_max(wseq_max(T_SFA, N_LOW), N_GAP),
                                           wseq_max(T_PEPWL, T_PEPWH));
  localparam int unsigned TW    = $clog2(N_MAX + 1) + 1;

  logic          full_q;
  logic          tmr_load;
  logic [TW-1:0] tmr_val;
  logic          tmr_exp;

  fifo_wr_seq_flag u_flag (
    .clk       (clk),
    .fifo_full (fifo_full),
    .full_q    (full_q)
  );

  fifo_wr_seq_timer #(.TW(TW)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .load   (tmr_load),
    .val    (tmr_val),
    .expire (tmr_exp)
  );

  fifo_wr_seq_fsm #(
    .AW    (AW),
    .DW    (DW),
    .TW    (TW),
    .N_SFA (T_SFA),
    .N_LOW (N_LOW),
    .N_GAP (N_GAP),
    .N_PLO (T_PEPWL),
    .N_PHI (T_PEPWH)
  ) u_fsm (
    .clk           (clk),
    .rst           (rst),
    .s_addr        (s_addr),
    .s_data        (s_data),
    .s_valid       (s_valid),
    .s_ready       (s_ready),
    .pkt_req       (pkt_req),
    .pkt_ready     (pkt_ready),
    .full_q        (full_q),
    .tmr_load      (tmr_load),
    .tmr_val       (tmr_val),
    .tmr_exp       (tmr_exp),
    .fifo_addr     (fifo_addr),
    .fifo_cs_n     (fifo_cs_n),
    .fifo_wr_n     (fifo_wr_n),
    .fifo_data     (fifo_data),
    .fifo_pktend_n (fifo_pktend_n)
  );

endmodule

// File: rtl/fifo_wr_seq_chk.sv
module fifo_wr_seq_chk #(
  parameter int unsigned AW      = 2,
  parameter int unsigned DW      = 8,
  parameter int unsigned T_WRPWL = 1,
  parameter int unsigned T_WRPWH = 1,
  parameter int unsigned T_SFD   = 1,
  parameter int unsigned T_PEPWL = 1
) (
  input logic          clk,
  input logic          rst,
  input logic          s_valid,
  input logic          s_ready,
  input logic          pkt_ready,
  input logic [AW-1:0] fifo_addr,
  input logic          fifo_cs_n,
  input logic          fifo_wr_n,
  input logic [DW-1:0] fifo_data,
  input logic          fifo_pktend_n,
  input logic          fifo_full
);

  logic [7:0] lo_cnt, hi_cnt, pe_lo_cnt;
  logic       seen_strobe;

  always_ff @(posedge clk) begin
    if (rst) begin
      lo_cnt      <= '0;
      hi_cnt      <= '0;
      pe_lo_cnt   <= '0;
      seen_strobe <= 1'b0;
    end else begin
      lo_cnt    <= !fifo_wr_n ? ((lo_cnt == 8'hFF) ? lo_cnt : lo_cnt + 1'b1) : '0;
      hi_cnt    <=  fifo_wr_n ? ((hi_cnt == 8'hFF) ? hi_cnt : hi_cnt + 1'b1) : '0;
      pe_lo_cnt <= !fifo_pktend_n ? ((pe_lo_cnt == 8'hFF) ? pe_lo_cnt : pe_lo_cnt + 1'b1) : '0;
      if (!fifo_wr_n) seen_strobe <= 1'b1;
    end
  end

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (rst)
    !seen_strobe && fifo_wr_n |-> fifo_pktend_n && !pkt_ready);

  p_addr_wr_r2: assert property (@(posedge clk) disable iff (rst)
    !fifo_wr_n |-> $stable(fifo_addr));

  p_data_lo_r3: assert property (@(posedge clk) disable iff (rst)
    !fifo_wr_n && !$fell(fifo_wr_n) |-> $stable(fifo_data));

  p_data_hold_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_wr_n) |-> $stable(fifo_data));

  p_lo_width_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_wr_n) |-> (lo_cnt >= 8'(T_WRPWL)) && (lo_cnt >= 8'(T_SFD)));

  p_hi_width_r4: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_wr_n) && seen_strobe |-> hi_cnt >= 8'(T_WRPWH));

  p_cs_r5: assert property (@(posedge clk) disable iff (rst)
    !fifo_wr_n |-> !fifo_cs_n);

  p_full_r6: assert property (@(posedge clk) disable iff (rst)
    $past(fifo_full) |-> !s_ready);

  p_pkt_ready_r7: assert property (@(posedge clk) disable iff (rst)
    pkt_ready |-> !s_valid);

  p_pe_width_r7: assert property (@(posedge clk) disable iff (rst)
    $rose(fifo_pktend_n) |-> pe_lo_cnt >= 8'(T_PEPWL));

  p_excl_r8: assert property (@(posedge clk) disable iff (rst)
    !(!fifo_wr_n && !fifo_pktend_n));

  p_pe_after_hi_r8: assert property (@(posedge clk) disable iff (rst)
    $fell(fifo_pktend_n) |-> hi_cnt >= 8'(T_WRPWH));

  p_addr_pe_r9: assert property (@(posedge clk) disable iff (rst)
    !fifo_pktend_n |-> $stable(fifo_addr));

endmodule

bind fifo_wr_seq fifo_wr_seq_chk #(
  .AW      (AW),
  .DW      (DW),
  .T_WRPWL (T_WRPWL),
  .T_WRPWH (T_WRPWH),
  .T_SFD   (T_SFD),
  .T_PEPWL (T_PEPWL)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .s_valid       (s_valid),
  .s_ready       (s_ready),
  .pkt_ready     (pkt_ready),
  .fifo_addr     (fifo_addr),
  .fifo_cs_n     (fifo_cs_n),
  .fifo_wr_n     (fifo_wr_n),
  .fifo_data     (fifo_data),
  .fifo_pktend_n (fifo_pktend_n),
  .fifo_full     (fifo_full)
);

// File: tb/tb_fifo_wr_seq.sv
module tb_fifo_wr_seq;

  localparam int AW = 2, DW = 8;
  localparam int T_SFA = 2, T_WRPWL = 3, T_WRPWH = 2, T_SFD = 2, T_FDH = 1;
  localparam int T_XFLG = 2, T_PEPWL = 2, T_PEPWH = 3;
  localparam int LOW_E = (T_WRPWL > T_SFD) ? T_WRPWL : T_SFD;
  localparam int HIW_A = (T_WRPWH > T_FDH) ? T_WRPWH : T_FDH;
  localparam int HIW_E = (HIW_A > T_XFLG + 1) ? HIW_A : T_XFLG + 1;
  localparam int NV = 8;
  localparam int WD_LIMIT = 20000;

  // vector: {addr[10:9], data[8:1], commit after this byte[0]}
  localparam logic [10:0] VEC [NV] = '{
    {2'd1, 8'h11, 1'b0}, {2'd1, 8'h22, 1'b0}, {2'd1, 8'h33, 1'b0}, {2'd1, 8'h44, 1'b1},
    {2'd2, 8'h55, 1'b0}, {2'd2, 8'h66, 1'b1}, {2'd0, 8'h77, 1'b0}, {2'd3, 8'h88, 1'b1}
  };

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] s_addr = '0;
  logic [DW-1:0] s_data = '0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic          pkt_req = 1'b0;
  logic          pkt_ready;
  logic [AW-1:0] fifo_addr;
  logic          fifo_cs_n;
  logic          fifo_wr_n;
  logic [DW-1:0] fifo_data;
  logic          fifo_pktend_n;
  logic          fifo_full = 1'b0;

  int n_chk = 0, n_fail = 0, cyc = 0;

  always #10 clk = ~clk;

  fifo_wr_seq #(
    .AW(AW), .DW(DW), .T_SFA(T_SFA), .T_WRPWL(T_WRPWL), .T_WRPWH(T_WRPWH),
    .T_SFD(T_SFD), .T_FDH(T_FDH), .T_XFLG(T_XFLG), .T_PEPWL(T_PEPWL), .T_PEPWH(T_PEPWH)
  ) dut (
    .clk(clk), .rst(rst), .s_addr(s_addr), .s_data(s_data), .s_valid(s_valid),
    .s_ready(s_ready), .pkt_req(pkt_req), .pkt_ready(pkt_ready),
    .fifo_addr(fifo_addr), .fifo_cs_n(fifo_cs_n), .fifo_wr_n(fifo_wr_n),
    .fifo_data(fifo_data), .fifo_pktend_n(fifo_pktend_n), .fifo_full(fifo_full)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  // pin monitor, sampled on the falling edge
  int n_str = 0, n_pe = 0, age = 0, lo_run = 0, hi_run = 0, pe_lo_run = 0, pe_hi_run = 0;
  int overlap = 0, cs_bad = 0;
  int setup_w [16], lo_w [16], hi_w [16], cap_a [16], cap_d [16];
  int pa = 0, pd = 0, pe_addr = 0;
  bit pwr = 1'b1, ppe = 1'b1, pe_pending = 1'b0;

  always @(negedge clk) begin
    if (rst) begin
      age = 0; lo_run = 0; hi_run = 0; pe_lo_run = 0; pe_hi_run = 0; pe_pending = 1'b0;
      pwr = 1'b1; ppe = 1'b1; pa = int'(fifo_addr); pd = int'(fifo_data);
    end else begin
      if (int'(fifo_addr) != pa) age = 1; else if (age < 100000) age++;
      if (!fifo_wr_n && pwr && n_str < 16) begin
        setup_w[n_str] = age - 1;
        hi_w[n_str]    = hi_run;
        if (pe_pending) begin
          chk(pe_hi_run >= T_PEPWH, "R7 pktend high before strobe", pe_hi_run, T_PEPWH);
          pe_pending = 1'b0;
        end
      end
      if (fifo_wr_n && !pwr) begin
        if (n_str < 16) begin
          lo_w[n_str] = lo_run; cap_a[n_str] = pa; cap_d[n_str] = pd;
        end
        n_str++;
      end
      if (!fifo_pktend_n && ppe) begin
        chk(hi_run >= T_WRPWH, "R8 strobe high before pktend", hi_run, T_WRPWH);
        pe_addr = int'(fifo_addr);
      end
      if (fifo_pktend_n && !ppe) begin
        chk(pe_lo_run == T_PEPWL, "R7 pktend low width", pe_lo_run, T_PEPWL);
        chk(pe_addr == pa, "R9 address during pktend", pa, pe_addr);
        n_pe++; pe_pending = 1'b1; pe_hi_run = 0;
      end
      if (!fifo_wr_n && !fifo_pktend_n) overlap++;
      if (!fifo_wr_n && fifo_cs_n) cs_bad++;
      if (!fifo_wr_n) begin lo_run++; hi_run = 0; end else begin hi_run++; lo_run = 0; end
      if (!fifo_pktend_n) begin pe_lo_run++; end else begin pe_hi_run++; pe_lo_run = 0; end
      pwr = fifo_wr_n; ppe = fifo_pktend_n; pa = int'(fifo_addr); pd = int'(fifo_data);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == WD_LIMIT) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", cyc, 0);
      summary();
    end
  end

  // entered and left on a falling edge; s_valid stays high on return
  task automatic send(input int a, input int d);
    s_valid = 1'b1; s_addr = AW'(a); s_data = DW'(d);
    while (!s_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic commit();
    s_valid = 1'b0; pkt_req = 1'b1;
    while (!pkt_ready) @(negedge clk);
    @(negedge clk);
    pkt_req = 1'b0;
  endtask

  initial begin
    int snap;
    repeat (3) @(negedge clk);
    // R1: pins during reset
    chk(fifo_wr_n && fifo_cs_n && fifo_pktend_n, "R1 pins in reset", {fifo_cs_n, fifo_wr_n, fifo_pktend_n}, 7);
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(fifo_wr_n && fifo_cs_n && fifo_pktend_n, "R1 pins after reset", {fifo_cs_n, fifo_wr_n, fifo_pktend_n}, 7);
    chk(s_ready == 1'b1, "R1 s_ready after reset", s_ready, 1);
    chk(pkt_ready == 1'b0, "R1 pkt_ready after reset", pkt_ready, 0);

    // table walk
    for (int i = 0; i < NV; i++) begin
      send(int'(VEC[i][10:9]), int'(VEC[i][8:1]));
      if (VEC[i][0]) commit();
    end
    s_valid = 1'b0;
    repeat (20) @(negedge clk);

    chk(n_str == NV, "R10 strobe count", n_str, NV);
    chk(n_pe == 3, "R7 pktend count", n_pe, 3);
    for (int k = 0; k < NV; k++) begin
      chk(cap_a[k] == int'(VEC[k][10:9]), "R10 captured address", cap_a[k], int'(VEC[k][10:9]));
      chk(cap_d[k] == int'(VEC[k][8:1]), "R10 captured data", cap_d[k], int'(VEC[k][8:1]));
      chk(lo_w[k] == LOW_E, "R3 strobe low width", lo_w[k], LOW_E);
      if (k > 0) chk(hi_w[k] >= T_WRPWH, "R4 strobe high minimum", hi_w[k], T_WRPWH);
      if (k > 0 && VEC[k][10:9] == VEC[k-1][10:9] && !VEC[k-1][0])
        chk(hi_w[k] == HIW_E, "R4 burst high width", hi_w[k], HIW_E);
      if (k == 0 || VEC[k][10:9] != VEC[k-1][10:9])
        chk(setup_w[k] == T_SFA, "R2 address setup", setup_w[k], T_SFA);
    end
    chk(overlap == 0, "R8 strobe overlap cycles", overlap, 0);
    chk(cs_bad == 0, "R5 select high during strobe", cs_bad, 0);
    chk(pkt_ready == 1'b1, "R7 pkt_ready when idle", pkt_ready, 1);

    // full flag stall
    fifo_full = 1'b1;
    @(negedge clk);
    chk(s_ready == 1'b0, "R6 s_ready one cycle after full", s_ready, 0);
    snap = n_str;
    s_valid = 1'b1; s_addr = 2'd3; s_data = 8'h99;
    @(negedge clk);
    chk(pkt_ready == 1'b0, "R7 pkt_ready with s_valid high", pkt_ready, 0);
    repeat (10) @(negedge clk);
    chk(s_ready == 1'b0, "R6 s_ready held low while full", s_ready, 0);
    chk(n_str == snap, "R6 no strobe while full", n_str, snap);
    fifo_full = 1'b0;
    @(negedge clk);
    chk(s_ready == 1'b1, "R6 s_ready after full clears", s_ready, 1);
    @(negedge clk);
    s_valid = 1'b0;
    repeat (10) @(negedge clk);
    chk(n_str == snap + 1, "R6 strobe after full clears", n_str, snap + 1);
    chk(cap_d[snap] == 8'h99, "R10 data after stall", cap_d[snap], 8'h99);
    chk(lo_w[snap] == LOW_E, "R3 low width after stall", lo_w[snap], LOW_E);
    chk(overlap == 0 && cs_bad == 0, "R8 R5 pin rules at end", overlap + cs_bad, 0);

    summary();
  end

endmodule